// File: doc/BRIEF.md
# Circular and Bit-Reverse Address Generator

This unit sits in the address stage of a DSP core. It computes one memory address per request. It holds four buffer descriptors, and each descriptor has four registers: a pointer, a start address, a length and a default step. A request selects one descriptor and one of four addressing forms:
- **Immediate:** an absolute address carried by the request.
- **Pre-step:** the stepped pointer goes out as the address and is also stored.
- **Post-step:** the current pointer goes out as the address, and the stepped value is stored.
- **Reverse-carry post-step:** used for FFT reordering.

When circular stepping is selected and the length is non-zero, a pointer that runs past either end of the buffer folds back by one length. The start address and the length may take any value; no alignment is required. The step is signed. A step whose magnitude is larger than the length is limited to the length, and this sets a sticky error flag.

The address path is purely combinational. The address, the next pointer and the alignment flag are valid in the same cycle as `req_valid`. The pointer register takes the new value on the following clock edge, so a request in the next cycle already sees it. Each request also states an access width of one, two or four 32-bit words. The unit flags a two-word access at an odd address and a four-word access at an address that is not a multiple of four. The address is still returned in both cases.

Top module: `addr_gen_circ`

## Requirements
- R1: After reset, every descriptor register of every buffer reads as zero and `mod_err` is 0.
- R2: A register write uses `wr_reg` codes 0 = pointer, 1 = start, 2 = length, 3 = default step. The written value is seen by requests from the next cycle on. If a request updates the same buffer's pointer in the same cycle that the pointer is written, the write wins.
- R3: Pre-step (`req_mode` = 1) drives the stepped pointer onto `addr_out` and stores it as the new pointer.
- R4: Post-step (`req_mode` = 2) drives the old pointer onto `addr_out`, presents the stepped value on `ptr_out` and stores it.
- R5: With `req_circ` = 1 and a non-zero length, a stepped pointer at or above start+length is reduced by the length, and one below the start is raised by the length. This holds for any start and length.
- R6: A length of zero turns off folding. The pointer then steps linearly, modulo 2^AW.
- R7: Reverse-carry post-step (`req_mode` = 3) drives the old pointer onto `addr_out`. The new pointer is start + rev(rev(pointer − start) + rev(step)), with rev taken over AW bits. A step of N/2 from the start therefore visits start + bitreverse_k(i) for N = 2^k.
- R8: Immediate (`req_mode` = 0) drives `req_mod` onto `addr_out`, leaves the pointer unchanged and does not touch `mod_err`.
- R9: `req_mod_sel` = 1 takes the step from `req_mod`. `req_mod_sel` = 0 takes it from the buffer's step register.
- R10: If the length is non-zero and the step's magnitude exceeds it, the step is replaced by ±length (keeping its sign) and `mod_err` is set. `mod_err` then stays at 1 until reset.
- R11: `req_size` codes are 0 = single, 1 = dual, 2 or 3 = quad. `misalign` is 1 for a dual access at an odd address and for a quad access at an address whose two low bits are not both zero. It is 0 otherwise and whenever `req_valid` is 0.
- R12: A cycle with neither `req_valid` nor `wr_en` leaves every pointer unchanged.
- R13: A request changes only the pointer of the buffer it selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_buf | input | 2 | Buffer selected for the write |
| wr_reg | input | 2 | Register code (0 pointer, 1 start, 2 length, 3 step) |
| wr_data | input | 16 | Write value |
| req_valid | input | 1 | Address request present |
| req_buf | input | 2 | Buffer selected for the request |
| req_mode | input | 2 | 0 immediate, 1 pre-step, 2 post-step, 3 reverse-carry |
| req_circ | input | 1 | Enable circular folding |
| req_mod_sel | input | 1 | 1: step from req_mod, 0: step from register |
| req_mod | input | 16 | Signed step or immediate address |
| req_size | input | 2 | Access width code |
| addr_out | output | 16 | Memory address |
| ptr_out | output | 16 | Next pointer value |
| misalign | output | 1 | Alignment violation |
| mod_err | output | 1 | Sticky step-range error |

## Verification
The bench sweeps every signed step from −length to +length over buffers whose starts are unaligned and whose lengths are 1, 5, 7 and 12. It compares each address against a modulo model. A design that compared against the wrong end, or that folded only in one direction, would go out of range on those runs.

Reverse-carry runs for N = 4, 8 and 16 start from an odd base and are compared with a bit-reversed counter. A design that reversed absolute addresses rather than offsets would produce the wrong order.

Separate checks cover the following:
- A write racing a request on the same buffer. A design that lets the request win loses the written pointer.
- Steps larger than the length, both positive and negative. A design without the clamp would leave the buffer.
- Every low-address and size combination for the alignment flag.

// File: rtl/addr_gen_circ.sv
module addr_gen_circ #(
  parameter int AW = 16,
  parameter int NBUF = 4,
  localparam int BW = $clog2(NBUF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_buf,
  input  logic [1:0]    wr_reg,
  input  logic [AW-1:0] wr_data,
  input  logic          req_valid,
  input  logic [BW-1:0] req_buf,
  input  logic [1:0]    req_mode,
  input  logic          req_circ,
  input  logic          req_mod_sel,
  input  logic [AW-1:0] req_mod,
  input  logic [1:0]    req_size,
  output logic [AW-1:0] addr_out,
  output logic [AW-1:0] ptr_out,
  output logic          misalign,
  output logic          mod_err
);
  localparam int W = AW + 2;
  localparam logic [1:0] M_IMM = 2'd0, M_PRE = 2'd1, M_POST = 2'd2, M_REV = 2'd3;

  logic [AW-1:0] idx_q [NBUF];
  logic [AW-1:0] base_q[NBUF];
  logic [AW-1:0] len_q [NBUF];
  logic [AW-1:0] step_q[NBUF];
  logic          err_q;

  function automatic logic [AW-1:0] rev(input logic [AW-1:0] v);
    for (int i = 0; i < AW; i++) rev[i] = v[AW-1-i];
  endfunction

  wire [AW-1:0] cur_idx  = idx_q[req_buf];
  wire [AW-1:0] cur_base = base_q[req_buf];
  wire [AW-1:0] cur_len  = len_q[req_buf];
  wire [AW-1:0] step_raw = req_mod_sel ? req_mod : step_q[req_buf];

  wire [W-1:0] step_ext = {{2{step_raw[AW-1]}}, step_raw};
  wire [W-1:0] len_ext  = {2'b00, cur_len};
  wire [W-1:0] base_ext = {2'b00, cur_base};
  wire [W-1:0] mag      = step_raw[AW-1] ? -step_ext : step_ext;
  wire         too_big  = (cur_len != '0) && (mag > len_ext);
  wire [W-1:0] step_eff = too_big ? (step_raw[AW-1] ? -len_ext : len_ext) : step_ext;

  wire [W-1:0] sum    = {2'b00, cur_idx} + step_eff;
  wire [W-1:0] lim    = base_ext + len_ext;
  wire [W-1:0] sum_dn = sum - len_ext;
  wire [W-1:0] sum_up = sum + len_ext;

  logic [AW-1:0] lin_res;
  always_comb begin
    lin_res = sum[AW-1:0];
    if (req_circ && cur_len != '0) begin
      if (!sum[W-1] && sum >= lim)            lin_res = sum_dn[AW-1:0];
      else if (sum[W-1] || sum < base_ext)    lin_res = sum_up[AW-1:0];
    end
  end

  wire [AW-1:0] off     = cur_idx - cur_base;
  wire [AW-1:0] rsum    = rev(off) + rev(step_eff[AW-1:0]);
  wire [AW-1:0] rev_res = cur_base + rev(rsum);

  always_comb begin
    case (req_mode)
      M_IMM:   ptr_out = cur_idx;
      M_REV:   ptr_out = rev_res;
      default: ptr_out = lin_res;
    endcase
    case (req_mode)
      M_IMM:   addr_out = req_mod;
      M_PRE:   addr_out = lin_res;
      default: addr_out = cur_idx;
    endcase
  end

  assign misalign = req_valid &&
                    ((req_size == 2'd1 && addr_out[0]) ||
                     (req_size[1] && addr_out[1:0] != 2'b00));
  assign mod_err = err_q;

  wire upd = req_valid && (req_mode != M_IMM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBUF; b++) begin
        idx_q[b]  <= '0;
        base_q[b] <= '0;
        len_q[b]  <= '0;
        step_q[b] <= '0;
      end
      err_q <= 1'b0;
    end else begin
      if (upd) idx_q[req_buf] <= ptr_out;
      if (wr_en) begin
        case (wr_reg)
          2'd0: idx_q[wr_buf]  <= wr_data;
          2'd1: base_q[wr_buf] <= wr_data;
          2'd2: len_q[wr_buf]  <= wr_data;
          default: step_q[wr_buf] <= wr_data;
        endcase
      end
      if (upd && too_big) err_q <= 1'b1;
    end
  end
endmodule

module addr_gen_circ_sva #(
  parameter int AW = 16,
  parameter int NBUF = 4,
  localparam int BW = $clog2(NBUF)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [BW-1:0] wr_buf,
  input logic [1:0]    wr_reg,
  input logic          req_valid,
  input logic [BW-1:0] req_buf,
  input logic [1:0]    req_mode,
  input logic          req_circ,
  input logic [1:0]    req_size,
  input logic [AW-1:0] addr_out,
  input logic [AW-1:0] ptr_out,
  input logic          misalign,
  input logic          mod_err,
  input logic [AW-1:0] idx_q [NBUF],
  input logic [AW-1:0] base_q[NBUF],
  input logic [AW-1:0] len_q [NBUF]
);
  wire [AW:0] lim    = {1'b0, base_q[req_buf]} + {1'b0, len_q[req_buf]};
  wire        in_buf = idx_q[req_buf] >= base_q[req_buf] && {1'b0, idx_q[req_buf]} < lim;
  wire        out_in = ptr_out >= base_q[req_buf] && {1'b0, ptr_out} < lim;

  assert_pre_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_mode == 2'd1 |-> addr_out == ptr_out);

  assert_post_old_ptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_mode[1] |-> addr_out == idx_q[req_buf]);

  assert_write_back_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_mode != 2'd0 && !(wr_en && wr_buf == req_buf && wr_reg == 2'd0)
    |=> idx_q[$past(req_buf)] == $past(ptr_out));

  assert_fold_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_circ && (req_mode == 2'd1 || req_mode == 2'd2) &&
    len_q[req_buf] != '0 && in_buf |-> out_in);

  assert_imm_keeps_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_mode == 2'd0 && !wr_en |=> $stable(idx_q[$past(req_buf)]));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mod_err |=> mod_err);

  assert_quad_misalign_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size[1] && addr_out[1:0] != 2'b00 |-> misalign);

  assert_no_flag_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || req_size == 2'd0) |-> !misalign);

  assert_idle_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid && !wr_en |=> $stable(idx_q[$past(req_buf)]));
endmodule

bind addr_gen_circ addr_gen_circ_sva #(.AW(AW), .NBUF(NBUF)) u_sva (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_buf(wr_buf), .wr_reg(wr_reg),
  .req_valid(req_valid), .req_buf(req_buf), .req_mode(req_mode), .req_circ(req_circ),
  .req_size(req_size), .addr_out(addr_out), .ptr_out(ptr_out), .misalign(misalign),
  .mod_err(mod_err), .idx_q(idx_q), .base_q(base_q), .len_q(len_q)
);

// File: tb/addr_gen_circ_bench.sv
module addr_gen_circ_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, req_valid = 0, req_circ = 0, req_mod_sel = 0;
  logic [1:0] wr_buf = 0, wr_reg = 0, req_buf = 0, req_mode = 0, req_size = 0;
  logic [15:0] wr_data = 0, req_mod = 0;
  logic [15:0] addr_out, ptr_out;
  logic misalign, mod_err;
  logic [15:0] g_addr, g_ptr;
  logic g_mis;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  addr_gen_circ u_addr_gen_circ (.*);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit we, input int wb, input int wr, input int wd,
                      input bit rv, input int rb, input int rm, input bit rc,
                      input bit rs, input int rmod, input int rsz);
    wr_en = we; wr_buf = 2'(wb); wr_reg = 2'(wr); wr_data = 16'(wd);
    req_valid = rv; req_buf = 2'(rb); req_mode = 2'(rm); req_circ = rc;
    req_mod_sel = rs; req_mod = 16'(rmod); req_size = 2'(rsz);
    #1;
    g_addr = addr_out; g_ptr = ptr_out; g_mis = misalign;
    @(negedge clk);
    wr_en = 0; req_valid = 0;
  endtask

  task automatic wreg(input int b, input int r, input int d);
    step(1, b, r, d, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic req(input int b, input int m, input bit c, input bit s, input int md, input int sz);
    step(0, 0, 0, 0, 1, b, m, c, s, md, sz);
  endtask

  task automatic cfg(input int b, input int base, input int len, input int idx);
    wreg(b, 1, base); wreg(b, 2, len); wreg(b, 0, idx);
  endtask

  function automatic int wrapm(input int p, input int base, input int len, input int m);
    int o = (p - base + m) % len;
    if (o < 0) o += len;
    return base + o;
  endfunction

  function automatic int revk(input int v, input int k);
    int r = 0;
    for (int i = 0; i < k; i++) if (v & (1 << i)) r |= 1 << (k - 1 - i);
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int bases[4] = '{3, 100, 1000, 50};
    int lens[4]  = '{5, 7, 1, 12};
    int p;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int b = 0; b < 4; b++) begin
      req(b, 0, 0, 0, 0, 0);
      check("R1 pointer after reset", g_ptr, 0);
    end
    check("R1 mod_err after reset", mod_err, 0);

    // R5 R4 circular post-step sweep over every legal step
    for (int c = 0; c < 4; c++) begin
      for (int m = -lens[c]; m <= lens[c]; m++) begin
        p = bases[c] + lens[c] / 2;
        cfg(c, bases[c], lens[c], p);
        for (int s = 0; s < 2 * lens[c] + 2; s++) begin
          req(c, 2, 1, 1, m, 0);
          check("R4 post address is old pointer", g_addr, p);
          p = wrapm(p, bases[c], lens[c], m);
          check("R5 circular post next pointer", g_ptr, p);
        end
      end
    end

    // R3 pre-step circular sweep
    for (int m = -7; m <= 7; m++) begin
      p = 101;
      cfg(1, 100, 7, p);
      for (int s = 0; s < 9; s++) begin
        p = wrapm(p, 100, 7, m);
        req(1, 1, 1, 1, m, 0);
        check("R3 pre address is stepped pointer", g_addr, p);
      end
    end

    // R6 zero length is linear
    cfg(3, 0, 0, 10);
    req(3, 2, 1, 1, 5, 0); check("R6 linear addr", g_addr, 10);
    req(3, 2, 1, 1, 5, 0); check("R6 linear addr", g_addr, 15);
    check("R6 linear ptr", g_ptr, 20);
    cfg(3, 4, 0, 2);
    req(3, 1, 1, 1, -3, 0); check("R6 no fold below base", g_addr, 16'hFFFF);

    // R7 R9 reverse-carry with step from register
    for (int k = 2; k <= 4; k++) begin
      cfg(2, 37, 1 << k, 37);
      wreg(2, 3, (1 << k) / 2);
      for (int i = 0; i < 2 * (1 << k); i++) begin
        req(2, 3, 0, 0, 999, 0);
        check("R7 reverse-carry order", g_addr, 37 + revk(i % (1 << k), k));
      end
    end

    // R9 register step versus request step
    cfg(3, 0, 0, 200);
    wreg(3, 3, 3);
    req(3, 2, 0, 0, 7, 0); check("R9 step from register", g_ptr, 203);
    req(3, 2, 0, 1, 7, 0); check("R9 step from request", g_ptr, 210);

    // R8 immediate
    req(3, 0, 1, 1, 16'h1235, 0);
    check("R8 immediate address", g_addr, 16'h1235);
    check("R8 immediate keeps pointer", g_ptr, 210);
    req(3, 2, 0, 1, 0, 0); check("R8 pointer unchanged after immediate", g_addr, 210);

    // R2 write wins over same-cycle update
    cfg(1, 0, 0, 50);
    step(1, 1, 0, 77, 1, 1, 2, 0, 1, 2, 0);
    check("R2 request sees old pointer", g_addr, 50);
    req(1, 2, 0, 1, 0, 0); check("R2 write beats update", g_addr, 77);

    // R12 idle cycles keep pointer
    repeat (5) @(negedge clk);
    req(1, 2, 0, 1, 0, 0); check("R12 pointer held while idle", g_addr, 77);

    // R13 independence
    cfg(0, 0, 0, 300);
    cfg(1, 0, 0, 400);
    repeat (3) req(0, 1, 0, 1, 4, 0);
    req(1, 2, 0, 1, 0, 0); check("R13 other buffer untouched", g_addr, 400);
    req(0, 2, 0, 1, 0, 0); check("R13 selected buffer advanced", g_addr, 312);

    // R10 clamp and sticky error
    check("R10 no error before overrange", mod_err, 0);
    cfg(0, 20, 5, 21);
    req(0, 2, 1, 1, 9, 0);  check("R10 positive clamp", g_ptr, 21);
    check("R10 error set", mod_err, 1);
    req(0, 2, 1, 1, -9, 0); check("R10 negative clamp", g_ptr, 21);
    req(0, 2, 1, 1, 1, 0);
    check("R10 error sticky", mod_err, 1);

    // R11 alignment flag
    for (int a = 0; a < 8; a++)
      for (int sz = 0; sz < 4; sz++) begin
        req(0, 0, 0, 1, 64 + a, sz);
        check("R11 address still returned", g_addr, 64 + a);
        check("R11 misalign flag", g_mis,
              sz == 1 ? (a % 2 != 0) : (sz >= 2 ? (a % 4 != 0) : 0));
      end
    #1 check("R11 no flag without request", misalign, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule